// File: doc/BRIEF.md
# Ethernet MAC Interrupt Status Controller

This block keeps the event flags of a small Ethernet controller and turns them into two interrupt requests. Single-cycle strobes from the MAC core set sticky flags in a transmit status register and a receive status register. A host on an 8-bit register bus reads those flags, clears any of them by writing a one into its position at the same address, and chooses which flags may interrupt through two read/write mask registers.

Two active-low outputs summarise the pending, enabled events: one for the transmit side and one for the receive side. The same two levels can be read in a read-only interrupt status register, so a host without interrupt lines can poll. The transmit status register also shows the live carrier-sense level, which is never latched and never interrupts.

Register map (3-bit address, reads are combinational, writes take effect at the rising clock edge): 0 transmit status (read flags / write-one-to-clear), 1 transmit mask, 2 receive status (read flags / write-one-to-clear), 3 receive mask, 4 interrupt status (read-only), 5 to 7 unused.

Top module: `ims_ctrl`

## Requirements
- R1: After reset, both status registers and both mask registers read 0x00, both summary outputs are high, and the interrupt status register reads 0x03.
- R2: A strobe on a transmit event line sets the flag in the same bit position of the transmit status register (bit7 sent OK, bit5 own frame seen, bit4 media shorted, bit3 underflow, bit2 collision, bit1 sixteenth collision, bit0 parity error), and the flag stays set until the host clears it.
- R3: A host write to address 0 or 2 clears each flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged.
- R4: When an event strobe and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R5: Bit6 of the transmit status register reads the live carrier-sense input; it is not latched, a write cannot clear it, and it never drives the transmit summary.
- R6: The receive status register latches events into bit7 good frame, bit4 reset frame, bit3 runt, bit2 alignment error, bit1 CRC error and bit0 FIFO overflow; bits 6 and 5 always read 0 and strobes on those lines are ignored.
- R7: The transmit mask at address 1 and the receive mask at address 3 store all eight written bits and read them back unchanged.
- R8: The transmit summary output is low exactly when some latched transmit flag has its mask bit set; the receive summary behaves the same with the receive registers.
- R9: The interrupt status register at address 4 reads the receive summary in bit1, the transmit summary in bit0 and 0 in bits 7 to 2; writes to it change nothing.
- R10: Addresses 5 to 7 read 0x00 and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_addr | input | 3 | Register address |
| host_wr | input | 1 | Write strobe for one cycle |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for host_addr, combinational |
| tx_evt | input | 8 | Transmit event strobes, one per flag position (bit6 unused) |
| carrier_sense | input | 1 | Live carrier-sense level |
| rx_evt | input | 8 | Receive event strobes, one per flag position (bits 6 and 5 unused) |
| tx_irq_n | output | 1 | Transmit summary, low while an enabled transmit flag is set |
| rx_irq_n | output | 1 | Receive summary, low while an enabled receive flag is set |

## Verification
The assertions take for granted that event lines are strobes sampled at each edge, that the host drives a known address whenever it writes, and that a flag only falls when the host writes a one to its status address. The stimulus mixes directed cases (reset values, set against clear in one cycle, carrier sense under a clearing write, the unused receive positions and unused addresses) with seeded random cycles in which events are sparse, writes land on every address and the carrier level toggles, while a bench model predicts every read and both summary pins.

// File: rtl/ims_pkg.sv
package ims_pkg;

    localparam int REG_W  = 8;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] OFF_TX_STAT = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFF_TX_MASK = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] OFF_RX_STAT = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] OFF_RX_MASK = ADDR_W'(3);
    localparam logic [ADDR_W-1:0] OFF_IRQ     = ADDR_W'(4);

    localparam int CS_BIT = 6;

    // Positions that latch events; carrier sense and unused receive bits excluded.
    localparam logic [REG_W-1:0] TX_KEEP = 8'hBF;
    localparam logic [REG_W-1:0] RX_KEEP = 8'h9F;

    typedef struct packed {
        logic tx_stat_clr;
        logic tx_mask_we;
        logic rx_stat_clr;
        logic rx_mask_we;
    } wr_strobe_t;

endpackage

// File: rtl/ims_sticky_bank.sv
module ims_sticky_bank #(
    parameter int               W    = 8,
    parameter logic [W-1:0]     KEEP = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         clr_en,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] flags
);

    logic [W-1:0] clr_vec;
    logic [W-1:0] flags_nxt;

    always_comb begin
        clr_vec   = clr_en ? clr_bits : '0;
        // An event in the same cycle as a clear keeps the flag set.
        flags_nxt = (evt | (flags & ~clr_vec)) & KEEP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= flags_nxt;
        end
    end

endmodule

// File: rtl/ims_mask_reg.sv
module ims_mask_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            q <= wdata;
        end
    end

endmodule

// File: rtl/ims_host_decode.sv
module ims_host_decode
    import ims_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [REG_W-1:0]  tx_view,
    input  logic [REG_W-1:0]  tx_mask,
    input  logic [REG_W-1:0]  rx_view,
    input  logic [REG_W-1:0]  rx_mask,
    input  logic              tx_sum_n,
    input  logic              rx_sum_n,
    output wr_strobe_t        strobe,
    output logic [REG_W-1:0]  rdata
);

    always_comb begin
        strobe             = '0;
        strobe.tx_stat_clr = wr && (addr == OFF_TX_STAT);
        strobe.tx_mask_we  = wr && (addr == OFF_TX_MASK);
        strobe.rx_stat_clr = wr && (addr == OFF_RX_STAT);
        strobe.rx_mask_we  = wr && (addr == OFF_RX_MASK);
    end

    always_comb begin
        case (addr)
            OFF_TX_STAT: rdata = tx_view;
            OFF_TX_MASK: rdata = tx_mask;
            OFF_RX_STAT: rdata = rx_view;
            OFF_RX_MASK: rdata = rx_mask;
            OFF_IRQ:     rdata = {{(REG_W-2){1'b0}}, rx_sum_n, tx_sum_n};
            default:     rdata = '0;
        endcase
    end

endmodule

// File: rtl/ims_irq_summary.sv
module ims_irq_summary #(
    parameter int W = 8
) (
    input  logic [W-1:0] flags,
    input  logic [W-1:0] enables,
    output logic         irq_n
);

    always_comb begin
        irq_n = ~(|(flags & enables));
    end

endmodule

// File: rtl/ims_ctrl.sv
module ims_ctrl
    import ims_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic [REG_W-1:0]  host_wdata,
    output logic [REG_W-1:0]  host_rdata,
    input  logic [REG_W-1:0]  tx_evt,
    input  logic              carrier_sense,
    input  logic [REG_W-1:0]  rx_evt,
    output logic              tx_irq_n,
    output logic              rx_irq_n
);

    wr_strobe_t       strobe;
    logic [REG_W-1:0] tx_stat;
    logic [REG_W-1:0] rx_stat;
    logic [REG_W-1:0] tx_mask;
    logic [REG_W-1:0] rx_mask;
    logic [REG_W-1:0] tx_view;

    ims_sticky_bank #(.W(REG_W), .KEEP(TX_KEEP)) u_tx_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (tx_evt),
        .clr_en   (strobe.tx_stat_clr),
        .clr_bits (host_wdata),
        .flags    (tx_stat)
    );

    ims_sticky_bank #(.W(REG_W), .KEEP(RX_KEEP)) u_rx_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (rx_evt),
        .clr_en   (strobe.rx_stat_clr),
        .clr_bits (host_wdata),
        .flags    (rx_stat)
    );

    ims_mask_reg #(.W(REG_W)) u_tx_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (strobe.tx_mask_we),
        .wdata (host_wdata),
        .q     (tx_mask)
    );

    ims_mask_reg #(.W(REG_W)) u_rx_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (strobe.rx_mask_we),
        .wdata (host_wdata),
        .q     (rx_mask)
    );

    ims_irq_summary #(.W(REG_W)) u_tx_sum (
        .flags   (tx_stat),
        .enables (tx_mask),
        .irq_n   (tx_irq_n)
    );

    ims_irq_summary #(.W(REG_W)) u_rx_sum (
        .flags   (rx_stat),
        .enables (rx_mask),
        .irq_n   (rx_irq_n)
    );

    always_comb begin
        tx_view         = tx_stat;
        tx_view[CS_BIT] = carrier_sense;
    end

    ims_host_decode u_dec (
        .addr     (host_addr),
        .wr       (host_wr),
        .tx_view  (tx_view),
        .tx_mask  (tx_mask),
        .rx_view  (rx_stat),
        .rx_mask  (rx_mask),
        .tx_sum_n (tx_irq_n),
        .rx_sum_n (rx_irq_n),
        .strobe   (strobe),
        .rdata    (host_rdata)
    );

endmodule

// File: rtl/ims_ctrl_chk.sv
module ims_ctrl_chk
    import ims_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] host_addr,
    input logic              host_wr,
    input logic [REG_W-1:0]  host_wdata,
    input logic [REG_W-1:0]  host_rdata,
    input logic [REG_W-1:0]  tx_evt,
    input logic              carrier_sense,
    input logic [REG_W-1:0]  rx_evt,
    input logic              tx_irq_n,
    input logic              rx_irq_n,
    input logic [REG_W-1:0]  tx_stat,
    input logic [REG_W-1:0]  rx_stat,
    input logic [REG_W-1:0]  tx_mask,
    input logic [REG_W-1:0]  rx_mask
);

    AST_TX_EVT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(tx_evt & TX_KEEP)) |=> ((tx_stat & $past(tx_evt & TX_KEEP)) == $past(tx_evt & TX_KEEP))); // R4

    AST_TX_NO_SPURIOUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && host_addr == OFF_TX_STAT) |=> ((tx_stat & $past(tx_stat)) == $past(tx_stat))); // R3

    AST_RX_NO_SPURIOUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && host_addr == OFF_RX_STAT) |=> ((rx_stat & $past(rx_stat)) == $past(rx_stat))); // R3

    AST_RX_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr == OFF_RX_STAT) |-> (host_rdata[6:5] == 2'b00)); // R6

    AST_CS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr == OFF_TX_STAT) |-> (host_rdata[CS_BIT] == carrier_sense)); // R5

    AST_TX_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && host_addr == OFF_TX_MASK) |=> $stable(tx_mask)); // R7

    AST_RX_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && host_addr == OFF_RX_MASK) |=> $stable(rx_mask)); // R7

    AST_IRQ_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr == OFF_IRQ) |-> (host_rdata == {6'b0, rx_irq_n, tx_irq_n})); // R9

    AST_TX_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_irq_n) |-> (|(tx_stat & tx_mask))); // R8

    AST_RX_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_irq_n) |-> (|(rx_stat & rx_mask))); // R8

    AST_HIGH_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr > OFF_IRQ) |-> (host_rdata == 8'h00)); // R10

endmodule

bind ims_ctrl ims_ctrl_chk u_chk (.*);

// File: tb/tb_ims_ctrl.sv
module tb_ims_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] host_addr = '0;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic [7:0] tx_evt = '0;
    logic       carrier_sense = 1'b0;
    logic [7:0] rx_evt = '0;
    logic       tx_irq_n;
    logic       rx_irq_n;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [7:0] m_tx = '0, m_rx = '0, m_txm = '0, m_rxm = '0;

    always #10 clk = ~clk;

    ims_ctrl dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_addr     (host_addr),
        .host_wr       (host_wr),
        .host_wdata    (host_wdata),
        .host_rdata    (host_rdata),
        .tx_evt        (tx_evt),
        .carrier_sense (carrier_sense),
        .rx_evt        (rx_evt),
        .tx_irq_n      (tx_irq_n),
        .rx_irq_n      (rx_irq_n)
    );

    function automatic logic f_tx_n();
        return ~(|(m_tx & m_txm));
    endfunction

    function automatic logic f_rx_n();
        return ~(|(m_rx & m_rxm));
    endfunction

    function automatic logic [7:0] f_read(input logic [2:0] a, input logic cs);
        case (a)
            3'd0:    return (m_tx & 8'hBF) | {1'b0, cs, 6'b0};
            3'd1:    return m_txm;
            3'd2:    return m_rx;
            3'd3:    return m_rxm;
            3'd4:    return {6'b0, f_rx_n(), f_tx_n()};
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [2:0] a, input logic w, input logic [7:0] d,
                        input logic [7:0] te, input logic [7:0] re);
        logic [7:0] clr_t;
        logic [7:0] clr_r;
        @(negedge clk);
        host_addr = a; host_wr = w; host_wdata = d; tx_evt = te; rx_evt = re;
        @(posedge clk);
        clr_t = (w && a == 3'd0) ? d : 8'h00;
        clr_r = (w && a == 3'd2) ? d : 8'h00;
        m_tx = (te | (m_tx & ~clr_t)) & 8'hBF;
        m_rx = (re | (m_rx & ~clr_r)) & 8'h9F;
        if (w && a == 3'd1) m_txm = d;
        if (w && a == 3'd3) m_rxm = d;
    endtask

    task automatic rd(input logic [2:0] a, input string tag);
        @(negedge clk);
        host_addr = a; host_wr = 1'b0; tx_evt = '0; rx_evt = '0;
        #2;
        chk(tag, host_rdata, f_read(a, carrier_sense));
        chk({tag, " tx_irq_n"}, {7'b0, tx_irq_n}, {7'b0, f_tx_n()});
        chk({tag, " rx_irq_n"}, {7'b0, rx_irq_n}, {7'b0, f_rx_n()});
    endtask

    task automatic rd_all(input string tag);
        for (int a = 0; a < 8; a++) rd(3'(a), tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL R1 watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 1234;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        rd_all("R1 reset");
        chk("R1 irq reg", f_read(3'd4, 1'b0), 8'h03);

        // R2: transmit events latch, carrier not latched
        step(3'd0, 1'b0, 8'h00, 8'hFF, 8'h00);
        rd(3'd0, "R2 tx set");
        chk("R2 tx value", host_rdata, 8'hBF);
        step(3'd7, 1'b0, 8'h00, 8'h00, 8'h00);
        rd(3'd0, "R2 tx held");

        // R3: write-one-to-clear
        step(3'd0, 1'b1, 8'h00, 8'h00, 8'h00);
        rd(3'd0, "R3 zero write");
        step(3'd0, 1'b1, 8'h81, 8'h00, 8'h00);
        rd(3'd0, "R3 partial clear");
        chk("R3 value", host_rdata, 8'h3E);

        // R4: set wins over clear
        step(3'd0, 1'b1, 8'hFF, 8'h04, 8'h00);
        rd(3'd0, "R4 set wins tx");
        chk("R4 value", host_rdata, 8'h04);
        step(3'd2, 1'b1, 8'hFF, 8'h00, 8'h80);
        rd(3'd2, "R4 set wins rx");

        // R5: carrier sense live, not clearable, no interrupt
        step(3'd1, 1'b1, 8'h40, 8'h00, 8'h00);
        @(negedge clk); carrier_sense = 1'b1;
        step(3'd0, 1'b1, 8'h40, 8'h00, 8'h00);
        rd(3'd0, "R5 cs live");
        chk("R5 value", host_rdata, 8'h44);
        chk("R5 no irq", {7'b0, tx_irq_n}, 8'h01);
        @(negedge clk); carrier_sense = 1'b0;
        rd(3'd0, "R5 cs drop");

        // R6: receive unused bits
        step(3'd0, 1'b0, 8'h00, 8'h00, 8'hFF);
        rd(3'd2, "R6 rx set");
        chk("R6 value", host_rdata, 8'h9F);
        step(3'd2, 1'b1, 8'hFF, 8'h00, 8'h60);
        rd(3'd2, "R6 unused strobes");
        chk("R6 cleared", host_rdata, 8'h00);

        // R7: masks
        step(3'd1, 1'b1, 8'hA5, 8'h00, 8'h00);
        step(3'd3, 1'b1, 8'h5A, 8'h00, 8'h00);
        rd(3'd1, "R7 tx mask");
        rd(3'd3, "R7 rx mask");

        // R8/R9: summaries
        step(3'd1, 1'b1, 8'h04, 8'h00, 8'h02);
        rd(3'd4, "R9 irq reg tx low");
        step(3'd3, 1'b1, 8'h02, 8'h00, 8'h00);
        rd(3'd4, "R8 both low");
        chk("R8 pins", {6'b0, rx_irq_n, tx_irq_n}, 8'h00);

        // R9/R10: ignored writes
        step(3'd4, 1'b1, 8'hFF, 8'h00, 8'h00);
        for (int a = 5; a < 8; a++) step(3'(a), 1'b1, 8'hFF, 8'h00, 8'h00);
        rd_all("R10 ignored writes");

        // R8: seeded random traffic
        for (int i = 0; i < 1500; i++) begin
            logic [2:0] a;
            logic       w;
            logic [7:0] te;
            logic [7:0] re;
            a  = 3'($urandom_range(0, 7));
            w  = ($urandom_range(0, 3) == 0);
            te = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00;
            re = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00;
            if ($urandom_range(0, 7) == 0) begin
                @(negedge clk); carrier_sense = ~carrier_sense;
            end
            step(a, w, 8'($urandom), te, re);
            rd(3'($urandom_range(0, 7)), "R8 random");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule